// File: doc/BRIEF.md
# Lookup-Table DAC Code Selector

This block picks the 8-bit code that drives one programmable current generator. In normal operation a 6-bit temperature sample from a converter indexes a 64-entry table of 8-bit codes. The table entry that comes back becomes the registered output code. Each table row covers roughly 2.2 °C of a −40 °C to +100 °C span. Two mode bits change where the code comes from:
- The row-override bit replaces the live sample with a 6-bit manual row index.
- The direct bit bypasses the table and drives a written 8-bit code straight to the output.

A direction flag (sink or source) and a 2-bit full-scale range select are registered and passed on beside the code. The table is an external synchronous RAM with one read port: the block drives a read strobe and a row address, and the data appears on the cycle after the request. The block issues a table read only when the selected row could have changed: a sample strobe, a change of the manual index, or a change of mode. The output register never shows an intermediate value while a mode change is in progress.

Top module: `lut_code_sel`

## Requirements
- R1: With both mode bits low, a `sampleValid` strobe issues a table read at row `sampleVal`. The output code becomes the table entry at that row.
- R2: With `modeRowSel` high and `modeDirect` low, table reads use row `manualRow`. Converter strobes then issue no read and leave `dacCode` unchanged.
- R3: With `modeDirect` high, `dacCode` equals `directCode` one clock later, whatever `modeRowSel` holds. No table read is issued in this mode.
- R4: `sinkFlag` follows `dirSink` one clock later (0 = source, 1 = sink) and resets to 0.
- R5: `fullScale` follows the 2-bit `fsSel` one clock later and resets to 0.
- R6: After reset `dacCode` is 0 and stays 0 until the first table read completes.
- R7: A read is issued (`tblRd` high) in the cycle of its trigger. The table answers on the next edge, and `dacCode` takes the answer on the second clock edge after the trigger, not earlier.
- R8: When the block leaves direct mode, it issues a table read in that same cycle. Without a sample strobe, this read uses the most recent converter sample. `dacCode` keeps the direct value until the table data is captured.
- R9: In row-override mode, a change of `manualRow` alone issues a read, and `dacCode` becomes the entry at the new row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleVal | input | 6 | Converter sample (temperature row) |
| sampleValid | input | 1 | Strobe marking a new sample |
| modeRowSel | input | 1 | Take the table row from `manualRow` |
| modeDirect | input | 1 | Bypass the table and use `directCode` |
| manualRow | input | 6 | Manual table row index |
| directCode | input | 8 | Directly written output code |
| dirSink | input | 1 | Polarity: 0 source, 1 sink |
| fsSel | input | 2 | Full-scale range select |
| tblRd | output | 1 | Table read request |
| tblAddr | output | 6 | Table read row |
| tblData | input | 8 | Table read data, valid the cycle after `tblRd` |
| dacCode | output | 8 | Registered DAC code |
| sinkFlag | output | 1 | Registered polarity |
| fullScale | output | 2 | Registered full-scale select |

## Verification
The assertions check these on every cycle:
- The read address matches the active source in each mode.
- No reads occur in direct mode.
- `dacCode` captures the returned table word exactly one edge after a read.
- `dacCode` holds when no capture or direct load is due.
- The polarity and range outputs are registered copies of their inputs.

Only the bench scenarios show the rest. These are whether the returned word comes from the right row, the zero code before the first read, reads triggered by a mode change using the stored last sample, and sample strobes having no visible effect in row-override mode.

// File: rtl/lutsel_pkg.sv
package lutsel_pkg;
  typedef struct packed {
    logic issueRead;
    logic useManual;
    logic useLive;
    logic capture;
    logic takeDirect;
  } selStrobes_t;
endpackage

// File: rtl/lutsel_ctrl.sv
module lutsel_ctrl
  import lutsel_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             modeRowSel,
  input  logic             modeDirect,
  input  logic [ROW_W-1:0] manualRow,
  output selStrobes_t      strobes
);
  logic             prevRowSel;
  logic             prevDirect;
  logic [ROW_W-1:0] prevManual;
  logic             readPending;
  logic             modeChanged;
  logic             manualChanged;
  logic             wantRead;

  always_comb begin
    modeChanged   = (modeRowSel != prevRowSel) || (modeDirect != prevDirect);
    manualChanged = (manualRow != prevManual);
    wantRead      = !modeDirect &&
                    (modeChanged || (modeRowSel ? manualChanged : sampleValid));
    strobes.issueRead  = wantRead;
    strobes.useManual  = modeRowSel;
    strobes.useLive    = sampleValid;
    strobes.capture    = readPending && !modeDirect;
    strobes.takeDirect = modeDirect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRowSel  <= 1'b0;
      prevDirect  <= 1'b0;
      prevManual  <= '0;
      readPending <= 1'b0;
    end else begin
      prevRowSel  <= modeRowSel;
      prevDirect  <= modeDirect;
      prevManual  <= manualRow;
      readPending <= wantRead;
    end
  end
endmodule

// File: rtl/lutsel_path.sv
module lutsel_path
  import lutsel_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int CODE_W = 8,
  parameter int FS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStrobes_t       strobes,
  input  logic [ROW_W-1:0]  sampleVal,
  input  logic [ROW_W-1:0]  manualRow,
  input  logic [CODE_W-1:0] directCode,
  input  logic              dirSink,
  input  logic [FS_W-1:0]   fsSel,
  input  logic [CODE_W-1:0] tblData,
  output logic              tblRd,
  output logic [ROW_W-1:0]  tblAddr,
  output logic [CODE_W-1:0] dacCode,
  output logic              sinkFlag,
  output logic [FS_W-1:0]   fullScale
);
  logic [ROW_W-1:0] lastSample;

  always_comb begin
    tblRd = strobes.issueRead;
    if (strobes.useManual)    tblAddr = manualRow;
    else if (strobes.useLive) tblAddr = sampleVal;
    else                      tblAddr = lastSample;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= '0;
      dacCode    <= '0;
      sinkFlag   <= 1'b0;
      fullScale  <= '0;
    end else begin
      if (strobes.useLive) lastSample <= sampleVal;
      if (strobes.takeDirect)   dacCode <= directCode;
      else if (strobes.capture) dacCode <= tblData;
      sinkFlag  <= dirSink;
      fullScale <= fsSel;
    end
  end
endmodule

// File: rtl/lut_code_sel.sv
module lut_code_sel
  import lutsel_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int CODE_W = 8,
  parameter int FS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  sampleVal,
  input  logic              sampleValid,
  input  logic              modeRowSel,
  input  logic              modeDirect,
  input  logic [ROW_W-1:0]  manualRow,
  input  logic [CODE_W-1:0] directCode,
  input  logic              dirSink,
  input  logic [FS_W-1:0]   fsSel,
  output logic              tblRd,
  output logic [ROW_W-1:0]  tblAddr,
  input  logic [CODE_W-1:0] tblData,
  output logic [CODE_W-1:0] dacCode,
  output logic              sinkFlag,
  output logic [FS_W-1:0]   fullScale
);
  selStrobes_t strobes;

  lutsel_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .modeRowSel(modeRowSel), .modeDirect(modeDirect),
    .manualRow(manualRow), .strobes(strobes)
  );

  lutsel_path #(.ROW_W(ROW_W), .CODE_W(CODE_W), .FS_W(FS_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sampleVal(sampleVal), .manualRow(manualRow), .directCode(directCode),
    .dirSink(dirSink), .fsSel(fsSel), .tblData(tblData),
    .tblRd(tblRd), .tblAddr(tblAddr), .dacCode(dacCode),
    .sinkFlag(sinkFlag), .fullScale(fullScale)
  );
endmodule

// File: rtl/lutsel_checker.sv
module lutsel_checker #(
  parameter int ROW_W  = 6,
  parameter int CODE_W = 8,
  parameter int FS_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ROW_W-1:0]  sampleVal,
  input logic              sampleValid,
  input logic              modeRowSel,
  input logic              modeDirect,
  input logic [ROW_W-1:0]  manualRow,
  input logic [CODE_W-1:0] directCode,
  input logic              dirSink,
  input logic [FS_W-1:0]   fsSel,
  input logic              tblRd,
  input logic [ROW_W-1:0]  tblAddr,
  input logic [CODE_W-1:0] tblData,
  input logic [CODE_W-1:0] dacCode,
  input logic              sinkFlag,
  input logic [FS_W-1:0]   fullScale
);
  p_live_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tblRd && !modeRowSel && sampleValid) |-> (tblAddr == sampleVal));

  p_manual_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tblRd && modeRowSel) |-> (tblAddr == manualRow));

  p_direct_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeDirect |=> (dacCode == $past(directCode)));

  p_direct_noread_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeDirect |-> !tblRd);

  p_sink_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sinkFlag == $past(dirSink)));

  p_fs_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fullScale == $past(fsSel)));

  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(tblRd) && !modeDirect) |=> (dacCode == $past(tblData)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!modeDirect && !$past(tblRd)) |=> $stable(dacCode));
endmodule

bind lut_code_sel lutsel_checker #(.ROW_W(ROW_W), .CODE_W(CODE_W), .FS_W(FS_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleVal(sampleVal), .sampleValid(sampleValid),
  .modeRowSel(modeRowSel), .modeDirect(modeDirect), .manualRow(manualRow),
  .directCode(directCode), .dirSink(dirSink), .fsSel(fsSel), .tblRd(tblRd),
  .tblAddr(tblAddr), .tblData(tblData), .dacCode(dacCode),
  .sinkFlag(sinkFlag), .fullScale(fullScale)
);

// File: tb/sim_lut_code_sel.sv
module sim_lut_code_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [5:0] smp;
    logic       rowSel;
    logic       direct;
    logic [5:0] man;
    logic [7:0] dcode;
    logic       dir;
    logic [1:0] fs;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{6'd5,  1'b0, 1'b0, 6'd0,  8'h00, 1'b0, 2'd0},
    '{6'd63, 1'b0, 1'b0, 6'd0,  8'h00, 1'b1, 2'd3},
    '{6'd0,  1'b0, 1'b0, 6'd0,  8'h00, 1'b0, 2'd1},
    '{6'd20, 1'b1, 1'b0, 6'd40, 8'h00, 1'b1, 2'd2},
    '{6'd33, 1'b1, 1'b0, 6'd40, 8'h00, 1'b0, 2'd0},
    '{6'd33, 1'b1, 1'b0, 6'd7,  8'h00, 1'b1, 2'd1},
    '{6'd10, 1'b0, 1'b1, 6'd7,  8'hA5, 1'b0, 2'd3},
    '{6'd10, 1'b1, 1'b1, 6'd7,  8'h3C, 1'b1, 2'd2},
    '{6'd50, 1'b0, 1'b0, 6'd7,  8'h00, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] sampleVal = '0;
  logic sampleValid = 1'b0;
  logic modeRowSel = 1'b0;
  logic modeDirect = 1'b0;
  logic [5:0] manualRow = '0;
  logic [7:0] directCode = '0;
  logic dirSink = 1'b0;
  logic [1:0] fsSel = '0;
  logic tblRd;
  logic [5:0] tblAddr;
  logic [7:0] tblData = '0;
  logic [7:0] dacCode;
  logic sinkFlag;
  logic [1:0] fullScale;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] lutVal(input logic [5:0] row);
    return 8'((int'(row) * 37 + 11) & 8'hFF);
  endfunction

  always_ff @(posedge clk) if (tblRd) tblData <= lutVal(tblAddr);

  lut_code_sel u0 (
    .clk(clk), .rstN(rstN), .sampleVal(sampleVal), .sampleValid(sampleValid),
    .modeRowSel(modeRowSel), .modeDirect(modeDirect), .manualRow(manualRow),
    .directCode(directCode), .dirSink(dirSink), .fsSel(fsSel),
    .tblRd(tblRd), .tblAddr(tblAddr), .tblData(tblData),
    .dacCode(dacCode), .sinkFlag(sinkFlag), .fullScale(fullScale)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseSample(input logic [5:0] s);
    sampleVal = s;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R6 reset code", int'(dacCode), 0);
    check("R4 reset sink", int'(sinkFlag), 0);
    check("R5 reset fs", int'(fullScale), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 no read yet", int'(dacCode), 0);

    for (int i = 0; i < NVEC; i++) begin
      modeRowSel = VECS[i].rowSel;
      modeDirect = VECS[i].direct;
      manualRow  = VECS[i].man;
      directCode = VECS[i].dcode;
      dirSink    = VECS[i].dir;
      fsSel      = VECS[i].fs;
      pulseSample(VECS[i].smp);
      @(negedge clk);
      if (VECS[i].direct)      exp = VECS[i].dcode;
      else if (VECS[i].rowSel) exp = lutVal(VECS[i].man);
      else                     exp = lutVal(VECS[i].smp);
      check(VECS[i].direct ? "R3 vector code" :
            (VECS[i].rowSel ? "R2 vector code" : "R1 vector code"),
            int'(dacCode), int'(exp));
      check("R4 vector sink", int'(sinkFlag), int'(VECS[i].dir));
      check("R5 vector fs", int'(fullScale), int'(VECS[i].fs));
    end

    // R7: latency of a live sample read
    held = dacCode;
    pulseSample(6'd17);
    check("R7 not yet updated", int'(dacCode), int'(held));
    @(negedge clk);
    check("R7 updated on second edge", int'(dacCode), int'(lutVal(6'd17)));

    // R3: direct one-cycle latency
    modeDirect = 1'b1;
    directCode = 8'h11;
    @(negedge clk);
    check("R3 direct latency", int'(dacCode), 8'h11);
    pulseSample(6'd42);
    @(negedge clk);
    check("R3 sample ignored in direct", int'(dacCode), 8'h11);

    // R8: leave direct mode without a strobe, last sample 42 used
    modeDirect = 1'b0;
    @(negedge clk);
    check("R8 direct value held", int'(dacCode), 8'h11);
    @(negedge clk);
    check("R8 table from last sample", int'(dacCode), int'(lutVal(6'd42)));

    // R9: manual index change alone triggers a read
    modeRowSel = 1'b1;
    manualRow  = 6'd42;
    repeat (3) @(negedge clk);
    manualRow = 6'd61;
    repeat (2) @(negedge clk);
    check("R9 manual change", int'(dacCode), int'(lutVal(6'd61)));

    // R2: converter strobe in row-override mode has no effect
    pulseSample(6'd3);
    repeat (2) @(negedge clk);
    check("R2 sample ignored", int'(dacCode), int'(lutVal(6'd61)));

    // R6: reset again returns code to zero
    rstN = 1'b0;
    @(negedge clk);
    check("R6 reset again", int'(dacCode), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule